// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that shares one memory between instructions and data and does all its arithmetic on a single ALU. It steps each instruction through a series of one-cycle states. Every instruction starts with a common fetch step and a common decode step. After that, the instruction class sets the path. A load takes five cycles, a store four, a register-to-register ALU operation four, a conditional branch three and a jump three. The sequencer reads only two things: the opcode of the instruction held in the instruction register, and the ALU overflow flag. From these it drives the enables, strobes and multiplexer selects of the surrounding datapath.

Every control output is a function of the current state alone. The opcode and the overflow flag affect only which state comes next. Two faults end an instruction early:

- an opcode that is not recognised;
- an overflow on an ALU operation.

In either case one exception cycle is inserted. That cycle saves the address of the faulting instruction (PC minus 4, worked out by the ALU) into an exception-PC register. It records a cause code and loads the PC from a vector address that depends on the cause.

The state register can be built as a binary-encoded register or as a one-hot register. The choice is an elaboration parameter, and the cycle behaviour is the same either way.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch state, at power-up or in the middle of an instruction. Fetch drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `ior_d`=0, `alu_src_a`=0, `alu_src_b`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00. All other outputs are 0.
- R2: The cycle after fetch is always decode. Decode drives `alu_src_a`=0, `alu_src_b`=11 (shifted offset) and `alu_op`=00, with every write enable and strobe at 0.
- R3: Opcode 6'b000000 (register ALU operation) goes from decode to an execute cycle (`alu_src_a`=1, `alu_src_b`=00, `alu_op`=10). If `alu_ovf` is 0 during that execute cycle, a write-back cycle follows (`reg_wr`=1, `reg_dst`=1, `mem_to_reg`=0) and then fetch, 4 cycles in total.
- R4: Opcode 6'b100011 (load) runs address (`alu_src_a`=1, `alu_src_b`=10, `alu_op`=00), then read (`mem_rd`=1, `ior_d`=1), then write-back (`reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0), 5 cycles in total. `mem_rd` and `mem_wr` are never both 1.
- R5: Opcode 6'b101011 (store) runs the same address cycle as a load, then a write cycle (`mem_wr`=1, `ior_d`=1), then fetch, 4 cycles in total.
- R6: Opcode 6'b000100 (branch on equal) runs one completion cycle (`alu_src_a`=1, `alu_src_b`=00, `alu_op`=01, `pc_src`=01, `pc_wr_cond`=1), then fetch, 3 cycles in total.
- R7: Opcode 6'b000010 (jump) runs one completion cycle (`pc_src`=10, `pc_wr`=1), then fetch, 3 cycles in total.
- R8: Any other opcode goes from decode to an undefined-instruction cycle, then fetch. That cycle drives `epc_wr`=1, `cause_wr`=1, `cause_val`=0, `exc_vector`=32'hC000_0000, `pc_src`=11, `pc_wr`=1, `alu_src_a`=0, `alu_src_b`=01 and `alu_op`=01.
- R9: If `alu_ovf` is 1 during the execute cycle of a register ALU operation, no write-back happens. An overflow cycle follows instead, with the same outputs as R8 except `cause_val`=1 and `exc_vector`=32'hC000_0020, and then fetch.
- R10: Outputs depend only on the state. A change of `opcode` or `alu_ovf` inside a cycle leaves the outputs unchanged. `alu_ovf` has no effect on any instruction other than in the execute cycle of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_ovf | input | 1 | ALU overflow flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU result is zero |
| ior_d | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| reg_dst | output | 1 | Destination register field: 0 = rt, 1 = rd |
| reg_wr | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU B input: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 exception vector |
| epc_wr | output | 1 | Exception-PC register load |
| cause_wr | output | 1 | Cause register load |
| cause_val | output | 2 | Cause code: 0 undefined opcode, 1 overflow |
| exc_vector | output | 32 | Exception vector address, zero outside exception cycles |

## Verification
The bench builds two copies of the block side by side. One uses the binary state encoding and one the one-hot encoding, both with the default 6-bit opcode and 32-bit vector, and every cycle's output word is compared on both. With 6-bit opcodes, all 64 opcode values can be swept, each with the overflow flag held low and held high. That covers every legal class, every undefined code, the overflow exit and the flag being ignored on the other classes. Separate runs wiggle the inputs in the middle of a cycle and assert reset in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   localparam int NUM_ST = 12;
   localparam int ST_W   = 4;

   typedef enum logic [ST_W-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_MADDR  = 4'd2,
      ST_MREAD  = 4'd3,
      ST_LDWB   = 4'd4,
      ST_MWRITE = 4'd5,
      ST_REXEC  = 4'd6,
      ST_RWB    = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9,
      ST_XUND   = 4'd10,
      ST_XOVF   = 4'd11
   } st_e;

   localparam logic [1:0] SRCB_REG  = 2'b00;
   localparam logic [1:0] SRCB_FOUR = 2'b01;
   localparam logic [1:0] SRCB_IMM  = 2'b10;
   localparam logic [1:0] SRCB_OFFS = 2'b11;

   localparam logic [1:0] AOP_ADD  = 2'b00;
   localparam logic [1:0] AOP_SUB  = 2'b01;
   localparam logic [1:0] AOP_FUNC = 2'b10;

   localparam logic [1:0] PCS_ALU = 2'b00;
   localparam logic [1:0] PCS_TGT = 2'b01;
   localparam logic [1:0] PCS_JMP = 2'b10;
   localparam logic [1:0] PCS_VEC = 2'b11;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       ior_d;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       mem_to_reg;
      logic       reg_dst;
      logic       reg_wr;
      logic       alu_src_a;
      logic [1:0] alu_src_b;
      logic [1:0] alu_op;
      logic [1:0] pc_src;
      logic       epc_wr;
      logic       cause_wr;
   } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
   import mc_ctrl_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter logic [OPC_W-1:0] OP_LW  = 6'b100011,
   parameter logic [OPC_W-1:0] OP_SW  = 6'b101011,
   parameter logic [OPC_W-1:0] OP_RT  = 6'b000000,
   parameter logic [OPC_W-1:0] OP_BEQ = 6'b000100,
   parameter logic [OPC_W-1:0] OP_J   = 6'b000010
) (
   input  st_e              cur,
   input  logic [OPC_W-1:0] opcode,
   input  logic             alu_ovf,
   output st_e              nxt
);

   logic is_mem;
   assign is_mem = (opcode == OP_LW) || (opcode == OP_SW);

   always_comb begin
      nxt = ST_FETCH;
      case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (is_mem)                nxt = ST_MADDR;
            else if (opcode == OP_RT)  nxt = ST_REXEC;
            else if (opcode == OP_BEQ) nxt = ST_BRANCH;
            else if (opcode == OP_J)   nxt = ST_JUMP;
            else                       nxt = ST_XUND;
         end
         ST_MADDR:  nxt = (opcode == OP_LW) ? ST_MREAD : ST_MWRITE;
         ST_MREAD:  nxt = ST_LDWB;
         ST_REXEC:  nxt = alu_ovf ? ST_XOVF : ST_RWB;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_state_reg.sv
module mc_ctrl_state_reg
   import mc_ctrl_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  st_e  nxt,
   output st_e  cur
);

   generate
      if (ONEHOT) begin : g_onehot
         logic [NUM_ST-1:0] oh_q;

         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_ST'(1) << ST_FETCH;
            else     oh_q <= NUM_ST'(1) << nxt;
         end

         always_comb begin
            cur = ST_FETCH;
            for (int i = 0; i < NUM_ST; i++) begin
               if (oh_q[i]) cur = st_e'(ST_W'(i));
            end
         end
      end else begin : g_binary
         st_e bin_q;

         always_ff @(posedge clk) begin
            if (rst) bin_q <= ST_FETCH;
            else     bin_q <= nxt;
         end

         assign cur = bin_q;
      end
   endgenerate

endmodule

// File: rtl/mc_ctrl_out_dec.sv
module mc_ctrl_out_dec
   import mc_ctrl_pkg::*;
#(
   parameter int                CAUSE_W   = 2,
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] VEC_UNDEF = 32'hC000_0000,
   parameter logic [ADDR_W-1:0] VEC_OVF   = 32'hC000_0020
) (
   input  st_e                cur,
   output ctrl_t              ctl,
   output logic [CAUSE_W-1:0] cause_val,
   output logic [ADDR_W-1:0]  vec
);

   always_comb begin
      ctl       = '0;
      cause_val = '0;
      vec       = '0;
      case (cur)
         ST_FETCH: begin
            ctl.mem_rd    = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.pc_wr     = 1'b1;
            ctl.alu_src_b = SRCB_FOUR;
            ctl.alu_op    = AOP_ADD;
            ctl.pc_src    = PCS_ALU;
         end
         ST_DECODE: begin
            ctl.alu_src_b = SRCB_OFFS;
            ctl.alu_op    = AOP_ADD;
         end
         ST_MADDR: begin
            ctl.alu_src_a = 1'b1;
            ctl.alu_src_b = SRCB_IMM;
            ctl.alu_op    = AOP_ADD;
         end
         ST_MREAD: begin
            ctl.mem_rd = 1'b1;
            ctl.ior_d  = 1'b1;
         end
         ST_LDWB: begin
            ctl.reg_wr     = 1'b1;
            ctl.mem_to_reg = 1'b1;
         end
         ST_MWRITE: begin
            ctl.mem_wr = 1'b1;
            ctl.ior_d  = 1'b1;
         end
         ST_REXEC: begin
            ctl.alu_src_a = 1'b1;
            ctl.alu_src_b = SRCB_REG;
            ctl.alu_op    = AOP_FUNC;
         end
         ST_RWB: begin
            ctl.reg_wr  = 1'b1;
            ctl.reg_dst = 1'b1;
         end
         ST_BRANCH: begin
            ctl.alu_src_a  = 1'b1;
            ctl.alu_src_b  = SRCB_REG;
            ctl.alu_op     = AOP_SUB;
            ctl.pc_src     = PCS_TGT;
            ctl.pc_wr_cond = 1'b1;
         end
         ST_JUMP: begin
            ctl.pc_src = PCS_JMP;
            ctl.pc_wr  = 1'b1;
         end
         ST_XUND, ST_XOVF: begin
            ctl.alu_src_b = SRCB_FOUR;
            ctl.alu_op    = AOP_SUB;
            ctl.epc_wr    = 1'b1;
            ctl.cause_wr  = 1'b1;
            ctl.pc_src    = PCS_VEC;
            ctl.pc_wr     = 1'b1;
            if (cur == ST_XOVF) begin
               cause_val = CAUSE_W'(1);
               vec       = VEC_OVF;
            end else begin
               vec       = VEC_UNDEF;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mc_ctrl_pkg::*;
#(
   parameter int                OPC_W        = 6,
   parameter logic [OPC_W-1:0]  OP_LW        = 6'b100011,
   parameter logic [OPC_W-1:0]  OP_SW        = 6'b101011,
   parameter logic [OPC_W-1:0]  OP_RT        = 6'b000000,
   parameter logic [OPC_W-1:0]  OP_BEQ       = 6'b000100,
   parameter logic [OPC_W-1:0]  OP_J         = 6'b000010,
   parameter int                CAUSE_W      = 2,
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] VEC_UNDEF    = 32'hC000_0000,
   parameter logic [ADDR_W-1:0] VEC_OVF      = 32'hC000_0020,
   parameter bit                STATE_ONEHOT = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OPC_W-1:0]   opcode,
   input  logic               alu_ovf,
   output logic               pc_wr,
   output logic               pc_wr_cond,
   output logic               ior_d,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               ir_wr,
   output logic               mem_to_reg,
   output logic               reg_dst,
   output logic               reg_wr,
   output logic               alu_src_a,
   output logic [1:0]         alu_src_b,
   output logic [1:0]         alu_op,
   output logic [1:0]         pc_src,
   output logic               epc_wr,
   output logic               cause_wr,
   output logic [CAUSE_W-1:0] cause_val,
   output logic [ADDR_W-1:0]  exc_vector
);

   // elaboration-time parameter checks
   generate
      if (OPC_W < 3) begin : g_bad_opc_w
         $error("OPC_W too narrow for five distinct opcodes");
      end
      if (OP_LW == OP_SW || OP_LW == OP_RT || OP_LW == OP_BEQ || OP_LW == OP_J ||
          OP_SW == OP_RT || OP_SW == OP_BEQ || OP_SW == OP_J ||
          OP_RT == OP_BEQ || OP_RT == OP_J || OP_BEQ == OP_J) begin : g_bad_opc
         $error("opcode parameters must be distinct");
      end
      if (CAUSE_W < 1) begin : g_bad_cause_w
         $error("CAUSE_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
      if (VEC_UNDEF == VEC_OVF) begin : g_bad_vec
         $error("exception vectors must differ");
      end
   endgenerate

   st_e   cur_st;
   st_e   nxt_st;
   ctrl_t ctl;

   mc_ctrl_next #(
      .OPC_W (OPC_W),
      .OP_LW (OP_LW),
      .OP_SW (OP_SW),
      .OP_RT (OP_RT),
      .OP_BEQ(OP_BEQ),
      .OP_J  (OP_J)
   ) u_next (
      .cur    (cur_st),
      .opcode (opcode),
      .alu_ovf(alu_ovf),
      .nxt    (nxt_st)
   );

   mc_ctrl_state_reg #(
      .ONEHOT(STATE_ONEHOT)
   ) u_state (
      .clk(clk),
      .rst(rst),
      .nxt(nxt_st),
      .cur(cur_st)
   );

   mc_ctrl_out_dec #(
      .CAUSE_W  (CAUSE_W),
      .ADDR_W   (ADDR_W),
      .VEC_UNDEF(VEC_UNDEF),
      .VEC_OVF  (VEC_OVF)
   ) u_dec (
      .cur      (cur_st),
      .ctl      (ctl),
      .cause_val(cause_val),
      .vec      (exc_vector)
   );

   assign pc_wr      = ctl.pc_wr;
   assign pc_wr_cond = ctl.pc_wr_cond;
   assign ior_d      = ctl.ior_d;
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign ir_wr      = ctl.ir_wr;
   assign mem_to_reg = ctl.mem_to_reg;
   assign reg_dst    = ctl.reg_dst;
   assign reg_wr     = ctl.reg_wr;
   assign alu_src_a  = ctl.alu_src_a;
   assign alu_src_b  = ctl.alu_src_b;
   assign alu_op     = ctl.alu_op;
   assign pc_src     = ctl.pc_src;
   assign epc_wr     = ctl.epc_wr;
   assign cause_wr   = ctl.cause_wr;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
   parameter int                OPC_W   = 6,
   parameter int                CAUSE_W = 2,
   parameter int                ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] VEC_OVF = 32'hC000_0020
) (
   input logic               clk,
   input logic               rst,
   input logic [OPC_W-1:0]   opcode,
   input logic               alu_ovf,
   input logic               pc_wr,
   input logic               pc_wr_cond,
   input logic               ior_d,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               ir_wr,
   input logic               mem_to_reg,
   input logic               reg_dst,
   input logic               reg_wr,
   input logic               alu_src_a,
   input logic [1:0]         alu_src_b,
   input logic [1:0]         alu_op,
   input logic [1:0]         pc_src,
   input logic               epc_wr,
   input logic               cause_wr,
   input logic [CAUSE_W-1:0] cause_val,
   input logic [ADDR_W-1:0]  exc_vector
);

   logic in_rexec;
   assign in_rexec = alu_src_a && (alu_op == 2'b10);

   p_reset_fetch_r1: assert property (@(posedge clk)
      rst |=> (ir_wr && mem_rd && pc_wr && !ior_d && pc_src == 2'b00));

   p_decode_follows_r2: assert property (@(posedge clk) disable iff (rst)
      ir_wr |=> (alu_src_b == 2'b11 && !pc_wr && !reg_wr && !mem_rd && !mem_wr));

   p_rtype_wb_r3: assert property (@(posedge clk) disable iff (rst)
      (in_rexec && !alu_ovf) |=> (reg_wr && reg_dst && !mem_to_reg));

   p_mem_excl_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mem_rd, mem_wr}));

   p_store_end_r5: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> ir_wr);

   p_branch_end_r6: assert property (@(posedge clk) disable iff (rst)
      pc_wr_cond |=> ir_wr);

   p_jump_end_r7: assert property (@(posedge clk) disable iff (rst)
      (pc_wr && pc_src == 2'b10) |=> ir_wr);

   p_exc_end_r8: assert property (@(posedge clk) disable iff (rst)
      cause_wr |=> (ir_wr && !cause_wr));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      (in_rexec && alu_ovf) |=> (!reg_wr && cause_wr && cause_val == CAUSE_W'(1)
                                 && exc_vector == VEC_OVF));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
   .OPC_W  (OPC_W),
   .CAUSE_W(CAUSE_W),
   .ADDR_W (ADDR_W),
   .VEC_OVF(VEC_OVF)
) u_chk (.*);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb_top;

   localparam int CW = 2;
   localparam int AW = 32;
   localparam int VW = 18 + CW + AW;

   localparam int S_F = 0, S_D = 1, S_MA = 2, S_MR = 3, S_LWB = 4, S_MW = 5;
   localparam int S_RX = 6, S_RWB = 7, S_BR = 8, S_J = 9, S_EU = 10, S_EO = 11;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'd0;
   logic       alu_ovf = 1'b0;

   int n_vec  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   // binary-encoded copy
   logic b_pcw, b_pcc, b_iod, b_mrd, b_mwr, b_irw, b_m2r, b_dst, b_rgw, b_sa, b_epc, b_cw;
   logic [1:0] b_sb, b_op, b_ps;
   logic [CW-1:0] b_cv;
   logic [AW-1:0] b_vec;
   // one-hot copy
   logic o_pcw, o_pcc, o_iod, o_mrd, o_mwr, o_irw, o_m2r, o_dst, o_rgw, o_sa, o_epc, o_cw;
   logic [1:0] o_sb, o_op, o_ps;
   logic [CW-1:0] o_cv;
   logic [AW-1:0] o_vec;

   mc_ctrl_fsm #(.CAUSE_W(CW), .ADDR_W(AW), .STATE_ONEHOT(1'b0)) dut_i (
      .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
      .pc_wr(b_pcw), .pc_wr_cond(b_pcc), .ior_d(b_iod), .mem_rd(b_mrd),
      .mem_wr(b_mwr), .ir_wr(b_irw), .mem_to_reg(b_m2r), .reg_dst(b_dst),
      .reg_wr(b_rgw), .alu_src_a(b_sa), .alu_src_b(b_sb), .alu_op(b_op),
      .pc_src(b_ps), .epc_wr(b_epc), .cause_wr(b_cw), .cause_val(b_cv),
      .exc_vector(b_vec));

   mc_ctrl_fsm #(.CAUSE_W(CW), .ADDR_W(AW), .STATE_ONEHOT(1'b1)) dut_oh_i (
      .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
      .pc_wr(o_pcw), .pc_wr_cond(o_pcc), .ior_d(o_iod), .mem_rd(o_mrd),
      .mem_wr(o_mwr), .ir_wr(o_irw), .mem_to_reg(o_m2r), .reg_dst(o_dst),
      .reg_wr(o_rgw), .alu_src_a(o_sa), .alu_src_b(o_sb), .alu_op(o_op),
      .pc_src(o_ps), .epc_wr(o_epc), .cause_wr(o_cw), .cause_val(o_cv),
      .exc_vector(o_vec));

   logic [VW-1:0] got_b, got_o;
   assign got_b = {b_pcw, b_pcc, b_iod, b_mrd, b_mwr, b_irw, b_m2r, b_dst, b_rgw,
                   b_sa, b_sb, b_op, b_ps, b_epc, b_cw, b_cv, b_vec};
   assign got_o = {o_pcw, o_pcc, o_iod, o_mrd, o_mwr, o_irw, o_m2r, o_dst, o_rgw,
                   o_sa, o_sb, o_op, o_ps, o_epc, o_cw, o_cv, o_vec};

   // expected output word for each step, taken from the requirements
   function automatic logic [VW-1:0] expv(input int s);
      logic pcw, pcc, iod, mrd, mwr, irw, m2r, dst, rgw, sa, epc, cw;
      logic [1:0] sb, op, ps;
      logic [CW-1:0] cv;
      logic [AW-1:0] vec;
      {pcw, pcc, iod, mrd, mwr, irw, m2r, dst, rgw, sa, epc, cw} = '0;
      sb = 2'b00; op = 2'b00; ps = 2'b00; cv = '0; vec = '0;
      case (s)
         S_F:   begin mrd = 1; irw = 1; pcw = 1; sb = 2'b01; end
         S_D:   begin sb = 2'b11; end
         S_MA:  begin sa = 1; sb = 2'b10; end
         S_MR:  begin mrd = 1; iod = 1; end
         S_LWB: begin rgw = 1; m2r = 1; end
         S_MW:  begin mwr = 1; iod = 1; end
         S_RX:  begin sa = 1; op = 2'b10; end
         S_RWB: begin rgw = 1; dst = 1; end
         S_BR:  begin sa = 1; op = 2'b01; ps = 2'b01; pcc = 1; end
         S_J:   begin ps = 2'b10; pcw = 1; end
         S_EU, S_EO: begin
            sb = 2'b01; op = 2'b01; epc = 1; cw = 1; ps = 2'b11; pcw = 1;
            cv  = (s == S_EO) ? CW'(1) : CW'(0);
            vec = (s == S_EO) ? 32'hC000_0020 : 32'hC000_0000;
         end
         default: ;
      endcase
      return {pcw, pcc, iod, mrd, mwr, irw, m2r, dst, rgw, sa, sb, op, ps, epc, cw, cv, vec};
   endfunction

   task automatic chk(input string req, input int s);
      logic [VW-1:0] e;
      e = expv(s);
      n_vec++;
      if (got_b !== e) begin
         n_fail++;
         $display("FAIL %s binary step %0d opc %b: got %h exp %h", req, s, opcode, got_b, e);
      end
      n_vec++;
      if (got_o !== e) begin
         n_fail++;
         $display("FAIL %s onehot step %0d opc %b: got %h exp %h", req, s, opcode, got_o, e);
      end
   endtask

   // run one instruction from fetch; called at a negedge in fetch
   task automatic run_instr(input logic [5:0] opc, input logic ovf);
      int    seq[5];
      int    len;
      string req;
      opcode  = opc;
      alu_ovf = ovf;
      seq[0] = S_F; seq[1] = S_D; seq[2] = S_F; seq[3] = S_F; seq[4] = S_F;
      case (opc)
         6'b100011: begin len = 5; seq[2] = S_MA; seq[3] = S_MR; seq[4] = S_LWB; req = "R4"; end
         6'b101011: begin len = 4; seq[2] = S_MA; seq[3] = S_MW; req = "R5"; end
         6'b000000: begin
            len = 4; seq[2] = S_RX;
            seq[3] = ovf ? S_EO : S_RWB;
            req    = ovf ? "R9" : "R3";
         end
         6'b000100: begin len = 3; seq[2] = S_BR; req = "R6"; end
         6'b000010: begin len = 3; seq[2] = S_J;  req = "R7"; end
         default:   begin len = 3; seq[2] = S_EU; req = "R8"; end
      endcase
      if (ovf && opc != 6'b000000) req = {req, "/R10"};
      for (int k = 0; k < len; k++) begin
         chk((k == 1) ? {req, "/R2"} : req, seq[k]);
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", S_F);                 // R1: reset state
      rst = 1'b0;

      // sweep of every opcode with the overflow flag low and high
      for (int o = 0; o < 64; o++) begin
         for (int v = 0; v < 2; v++) begin
            run_instr(6'(o), v[0]);
         end
      end

      // R10: input changes inside a cycle leave the outputs alone
      opcode = 6'b100011; alu_ovf = 1'b0;
      chk("R1", S_F);
      #3 opcode = 6'b000010; alu_ovf = 1'b1;
      #2 chk("R10", S_F);
      opcode = 6'b100011; alu_ovf = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R2", S_D);
      #2 opcode = 6'b111111; alu_ovf = 1'b1;
      #2 chk("R10", S_D);
      opcode = 6'b100011; alu_ovf = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R4", S_MA);
      @(posedge clk); @(negedge clk);
      chk("R4", S_MR);
      @(posedge clk); @(negedge clk);
      chk("R4", S_LWB);
      @(posedge clk); @(negedge clk);
      chk("R1", S_F);

      // R1: reset in the middle of a store
      opcode = 6'b101011;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      chk("R5", S_MA);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R1", S_F);
      rst = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R2", S_D);
      @(posedge clk); @(negedge clk);
      chk("R5", S_MA);
      @(posedge clk); @(negedge clk);
      chk("R5", S_MW);
      @(posedge clk); @(negedge clk);
      chk("R5", S_F);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule